// File: doc/BRIEF.md
# Byte/Word Bus Width Adapter

This block sits between a host bus that can be 8 or 16 bits wide and a 16-bit internal word interface. A byte-mode input picks the width. In x8 mode an extra lowest address bit chooses the high or low byte of each word, and only the low data lane is used. In x16 mode that extra bit is ignored and the word address maps straight through. The block makes no tri-state decisions itself. It raises one output-enable flag for each lane and leaves the pads to the next level up.

Writes come in as single-cycle strobes with a two-bit kind code. The command decoder upstream supplies that code. A plain data write becomes one registered word write, with byte enables. In x8 mode the block also supports a two-byte serial write. It takes three strobes: a setup write, then a first byte, then a second byte. The block merges the two bytes into one full word write. If the sequence is started in x16 mode, or broken by any write that is not an x8 data write, it is dropped and an error pulse is raised.

On reads, array and identifier words are steered onto the lanes. Status bytes always use the low lane only.

The write path has three states:
- `ST_IDLE`: waiting for a command.
- `ST_FIRST`: setup seen, waiting for the first byte.
- `ST_SECOND`: first byte held, waiting for the second byte.

The state transitions are:
- idle→first on an x8 setup write.
- idle→idle with an error on an x16 setup write.
- first→second on an x8 data write.
- first→idle with an error on any other write.
- second→idle with a merged word write on an x8 data write.
- second→idle with an error on any other write.

Top module: `bw_adapter`

## Requirements
- R1: In x8 mode (`byte_mode`=0) with the outputs enabled, array reads place the low byte of `arr_word` on `host_rdata[7:0]` when `lo_sel`=0 and the high byte when `lo_sel`=1. `host_rdata[15:8]` is 0, `lane_oe_lo`=1 and `lane_oe_hi`=0.
- R2: In x16 mode (`byte_mode`=1) with the outputs enabled, array reads put the whole of `arr_word` on `host_rdata`, whatever the value of `lo_sel`, and both lane enables are 1.
- R3: A status read (`rd_status`=1) with the outputs enabled returns `{8'h00, stat_byte}` with `lane_oe_lo`=1 and `lane_oe_hi`=0, in either mode.
- R4: When `ce_n`=1 or `oe_n`=1, both lane enables are 0 and `host_rdata` is 0.
- R5: An x8 data write (`wr_type`=2'b00) in `ST_IDLE` gives, on the next cycle, `word_we`=1 with the following values:
  - `word_addr` = the write address.
  - `word_data` = the low data byte copied onto both lanes.
  - `word_be` = 2'b10 when `lo_sel`=1 and 2'b01 when `lo_sel`=0.
- R6: An x16 data write in `ST_IDLE` gives, on the next cycle, `word_we`=1 with the full data word and `word_be`=2'b11. `lo_sel` has no effect.
- R7: An x8 setup write (`wr_type`=2'b01) followed by two x8 data writes produces exactly one word write, one cycle after the second byte, with the following values:
  - `word_addr` = the address given with the first byte.
  - The first byte sits in the lane chosen by its `lo_sel`, and the second byte fills the other lane.
  - `word_be`=2'b11.
- R8: A setup write in x16 mode produces no word write and pulses `serial_err` for one cycle on the next cycle. The adapter stays idle.
- R9: While a serial sequence waits for a byte, any write that is not an x8 data write abandons the sequence. No word write is made, `serial_err` pulses on the next cycle, and the next data write is handled as in R5/R6.
- R10: Other-command writes (`wr_type`=2'b10 or 2'b11) in `ST_IDLE` produce no word write and no error.
- R11: While `rst_n` is low, `word_we`, `serial_err`, `word_addr`, `word_data` and `word_be` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 = x16, 0 = x8 |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| lo_sel | input | 1 | Byte-select address bit below the word address (x8 only) |
| host_addr | input | AW | Word address |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_type | input | 2 | 00 data, 01 serial setup, 10/11 other command |
| host_wdata | input | 16 | Host write data |
| rd_status | input | 1 | 1 = read returns the status byte |
| arr_word | input | 16 | Array or identifier word to read |
| stat_byte | input | 8 | Status byte to read |
| host_rdata | output | 16 | Steered read data |
| lane_oe_lo | output | 1 | Drive enable for lanes 0-7 |
| lane_oe_hi | output | 1 | Drive enable for lanes 8-15 |
| word_we | output | 1 | Internal word write pulse |
| word_addr | output | AW | Internal word address |
| word_data | output | 16 | Internal word data |
| word_be | output | 2 | Byte enables, bit 1 = high lane |
| serial_err | output | 1 | One-cycle pulse when a serial write is abandoned |

## Verification
The write-path properties take the inputs as one sample per rising edge. `wr_stb`, `wr_type`, `byte_mode` and `lo_sel` are assumed to be held steady across that edge. A strobe counts once for each cycle it is high. The read-path properties assume that the lane enables depend only on the current mode, select and enable inputs, with no history.

The stimulus meets these assumptions as follows:
- It changes every input on the falling edge only.
- It keeps each strobe one cycle wide.
- It returns to idle between writes, so each sequence step is seen exactly once.

// File: rtl/bw_pkg.sv
package bw_pkg;

    typedef enum logic [1:0] {
        WK_DATA   = 2'b00,
        WK_SETUP  = 2'b01,
        WK_OTHER0 = 2'b10,
        WK_OTHER1 = 2'b11
    } wr_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FIRST  = 2'b01,
        ST_SECOND = 2'b10
    } pair_state_t;

endpackage

// File: rtl/bw_read_steer.sv
module bw_read_steer #(
    parameter int LANE_W = 8,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              rd_status,
    input  logic              lo_sel,
    input  logic [WORD_W-1:0] arr_word,
    input  logic [LANE_W-1:0] stat_byte,
    output logic [WORD_W-1:0] host_rdata,
    output logic              lane_oe_lo,
    output logic              lane_oe_hi
);

    logic drive_on;
    logic [LANE_W-1:0] sel_byte;

    assign drive_on = !ce_n && !oe_n;

    always_comb begin
        sel_byte   = lo_sel ? arr_word[WORD_W-1:LANE_W] : arr_word[LANE_W-1:0];
        lane_oe_lo = drive_on;
        lane_oe_hi = drive_on && byte_mode && !rd_status;
        host_rdata = '0;
        if (drive_on) begin
            if (rd_status)
                host_rdata = {{LANE_W{1'b0}}, stat_byte};
            else if (byte_mode)
                host_rdata = arr_word;
            else
                host_rdata = {{LANE_W{1'b0}}, sel_byte};
        end
    end

    // R1: the upper lane stays off in x8 mode
    p_hi_off_x8_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_mode |-> !lane_oe_hi);

    // R3: status reads never drive the upper lane
    p_status_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |-> (!lane_oe_hi && host_rdata[WORD_W-1:LANE_W] == '0));

    // R4: a deselected chip or high output enable drives no lane
    p_disable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!lane_oe_lo && !lane_oe_hi));

endmodule

// File: rtl/bw_write_pack.sv
module bw_write_pack
    import bw_pkg::*;
#(
    parameter int AW     = 17,
    parameter int LANE_W = 8,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              lo_sel,
    input  logic [AW-1:0]     host_addr,
    input  logic              wr_stb,
    input  logic [1:0]        wr_type,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              word_we,
    output logic [AW-1:0]     word_addr,
    output logic [WORD_W-1:0] word_data,
    output logic [1:0]        word_be,
    output logic              serial_err
);

    pair_state_t state, nxt;
    wr_kind_t    kind;
    logic        x8_data;
    logic        do_single, do_capture, do_pair, do_err;

    logic [AW-1:0]     cap_addr;
    logic              cap_hi;
    logic [LANE_W-1:0] cap_byte;
    logic [LANE_W-1:0] cur_byte;

    assign kind     = wr_kind_t'(wr_type);
    assign x8_data  = (kind == WK_DATA) && !byte_mode;
    assign cur_byte = host_wdata[LANE_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt        = state;
        do_single  = 1'b0;
        do_capture = 1'b0;
        do_pair    = 1'b0;
        do_err     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_stb && kind == WK_SETUP) begin
                    if (byte_mode)
                        do_err = 1'b1;
                    else
                        nxt = ST_FIRST;
                end else if (wr_stb && kind == WK_DATA) begin
                    do_single = 1'b1;
                end
            end
            ST_FIRST: begin
                if (wr_stb) begin
                    if (x8_data) begin
                        do_capture = 1'b1;
                        nxt        = ST_SECOND;
                    end else begin
                        do_err = 1'b1;
                        nxt    = ST_IDLE;
                    end
                end
            end
            ST_SECOND: begin
                if (wr_stb) begin
                    if (x8_data)
                        do_pair = 1'b1;
                    else
                        do_err = 1'b1;
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_we    <= 1'b0;
            serial_err <= 1'b0;
            word_addr  <= '0;
            word_data  <= '0;
            word_be    <= 2'b00;
            cap_addr   <= '0;
            cap_hi     <= 1'b0;
            cap_byte   <= '0;
        end else begin
            word_we    <= do_single || do_pair;
            serial_err <= do_err;
            if (do_capture) begin
                cap_addr <= host_addr;
                cap_hi   <= lo_sel;
                cap_byte <= cur_byte;
            end
            if (do_single) begin
                word_addr <= host_addr;
                if (byte_mode) begin
                    word_data <= host_wdata;
                    word_be   <= 2'b11;
                end else begin
                    word_data <= {cur_byte, cur_byte};
                    word_be   <= {lo_sel, !lo_sel};
                end
            end
            if (do_pair) begin
                word_addr <= cap_addr;
                word_data <= cap_hi ? {cap_byte, cur_byte} : {cur_byte, cap_byte};
                word_be   <= 2'b11;
            end
        end
    end

    // R7: the second x8 byte of a pair yields a full-word write
    p_pair_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECOND && wr_stb && wr_type == 2'b00 && !byte_mode)
            |=> (word_we && word_be == 2'b11));

    // R7: the first byte of a pair writes nothing
    p_first_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST && wr_stb) |=> !word_we);

    // R8: setup in x16 mode is refused
    p_setup_x16_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_stb && wr_type == 2'b01 && byte_mode)
            |=> (serial_err && !word_we));

    // R9: a broken sequence errors out and writes nothing
    p_broken_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && wr_stb && !(wr_type == 2'b00 && !byte_mode))
            |=> (serial_err && !word_we));

    // R10: other commands in idle never write
    p_other_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_stb && wr_type[1]) |=> (!word_we && !serial_err));

endmodule

// File: rtl/bw_adapter.sv
module bw_adapter #(
    parameter int AW     = 17,
    parameter int LANE_W = 8,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              lo_sel,
    input  logic [AW-1:0]     host_addr,
    input  logic              wr_stb,
    input  logic [1:0]        wr_type,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              rd_status,
    input  logic [WORD_W-1:0] arr_word,
    input  logic [LANE_W-1:0] stat_byte,
    output logic [WORD_W-1:0] host_rdata,
    output logic              lane_oe_lo,
    output logic              lane_oe_hi,
    output logic              word_we,
    output logic [AW-1:0]     word_addr,
    output logic [WORD_W-1:0] word_data,
    output logic [1:0]        word_be,
    output logic              serial_err
);

    bw_read_steer #(.LANE_W(LANE_W)) i_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_mode  (byte_mode),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .rd_status  (rd_status),
        .lo_sel     (lo_sel),
        .arr_word   (arr_word),
        .stat_byte  (stat_byte),
        .host_rdata (host_rdata),
        .lane_oe_lo (lane_oe_lo),
        .lane_oe_hi (lane_oe_hi)
    );

    bw_write_pack #(.AW(AW), .LANE_W(LANE_W)) i_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_mode  (byte_mode),
        .lo_sel     (lo_sel),
        .host_addr  (host_addr),
        .wr_stb     (wr_stb),
        .wr_type    (wr_type),
        .host_wdata (host_wdata),
        .word_we    (word_we),
        .word_addr  (word_addr),
        .word_data  (word_data),
        .word_be    (word_be),
        .serial_err (serial_err)
    );

endmodule

// File: tb/test_bw_adapter.sv
module test_bw_adapter;

    localparam int AW = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_mode = 1'b1, ce_n = 1'b1, oe_n = 1'b1, lo_sel = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic        wr_stb = 1'b0;
    logic [1:0]  wr_type = 2'b00;
    logic [15:0] host_wdata = '0;
    logic        rd_status = 1'b0;
    logic [15:0] arr_word = '0;
    logic [7:0]  stat_byte = '0;
    logic [15:0] host_rdata;
    logic        lane_oe_lo, lane_oe_hi;
    logic        word_we;
    logic [AW-1:0] word_addr;
    logic [15:0] word_data;
    logic [1:0]  word_be;
    logic        serial_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bw_adapter #(.AW(AW)) i_bw_adapter (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .ce_n(ce_n), .oe_n(oe_n),
        .lo_sel(lo_sel), .host_addr(host_addr), .wr_stb(wr_stb), .wr_type(wr_type),
        .host_wdata(host_wdata), .rd_status(rd_status), .arr_word(arr_word),
        .stat_byte(stat_byte), .host_rdata(host_rdata), .lane_oe_lo(lane_oe_lo),
        .lane_oe_hi(lane_oe_hi), .word_we(word_we), .word_addr(word_addr),
        .word_data(word_data), .word_be(word_be), .serial_err(serial_err)
    );

    always #4 clk = ~clk;

    // Behavioural reference of the write side
    int          seq = 0;
    logic [AW-1:0] s_addr;
    bit          s_hi;
    logic [7:0]  s_byte;
    bit          exp_we = 0, exp_err = 0;
    logic [AW-1:0] exp_addr;
    logic [15:0] exp_data;
    logic [1:0]  exp_be;
    string       exp_tag = "R10";

    always @(posedge clk) begin
        exp_we  = 0;
        exp_err = 0;
        exp_tag = "R10";
        if (!rst_n) begin
            seq = 0;
        end else if (wr_stb) begin
            bit x8data;
            x8data = (wr_type == 2'b00) && !byte_mode;
            if (seq == 0) begin
                if (wr_type == 2'b01) begin
                    if (byte_mode) begin exp_err = 1; exp_tag = "R8"; end
                    else begin seq = 1; exp_tag = "R7"; end
                end else if (wr_type == 2'b00) begin
                    exp_we = 1; exp_addr = host_addr;
                    if (byte_mode) begin
                        exp_tag = "R6"; exp_data = host_wdata; exp_be = 2'b11;
                    end else begin
                        exp_tag = "R5"; exp_data = {2{host_wdata[7:0]}};
                        exp_be = lo_sel ? 2'b10 : 2'b01;
                    end
                end
            end else if (seq == 1) begin
                if (x8data) begin
                    s_addr = host_addr; s_hi = lo_sel; s_byte = host_wdata[7:0];
                    seq = 2; exp_tag = "R7";
                end else begin
                    exp_err = 1; seq = 0; exp_tag = "R9";
                end
            end else begin
                if (x8data) begin
                    exp_we = 1; exp_addr = s_addr; exp_be = 2'b11; exp_tag = "R7";
                    exp_data = s_hi ? {s_byte, host_wdata[7:0]} : {host_wdata[7:0], s_byte};
                end else begin
                    exp_err = 1; exp_tag = "R9";
                end
                seq = 0;
            end
        end
    end

    // Compare every cycle, away from the edge
    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            checks++;
            if (word_we !== 1'b0 || serial_err !== 1'b0 || word_addr !== '0 ||
                word_data !== '0 || word_be !== 2'b00) begin
                fails++;
                $display("FAIL R11: we=%0b err=%0b addr=%0h data=%0h be=%0b expected all zero",
                         word_we, serial_err, word_addr, word_data, word_be);
            end
        end else begin
            logic [15:0] e_rd;
            bit e_lo, e_hi;
            string rtag;
            checks++;
            if (word_we !== exp_we || serial_err !== exp_err) begin
                fails++;
                $display("FAIL %s: we=%0b err=%0b expected we=%0b err=%0b",
                         exp_tag, word_we, serial_err, exp_we, exp_err);
            end
            if (exp_we) begin
                checks++;
                if (word_addr !== exp_addr || word_data !== exp_data || word_be !== exp_be) begin
                    fails++;
                    $display("FAIL %s: addr=%0h data=%0h be=%0b expected addr=%0h data=%0h be=%0b",
                             exp_tag, word_addr, word_data, word_be, exp_addr, exp_data, exp_be);
                end
            end
            e_rd = 16'h0000; e_lo = 0; e_hi = 0;
            if (ce_n || oe_n) rtag = "R4";
            else if (rd_status) begin
                rtag = "R3"; e_lo = 1; e_rd = {8'h00, stat_byte};
            end else if (byte_mode) begin
                rtag = "R2"; e_lo = 1; e_hi = 1; e_rd = arr_word;
            end else begin
                rtag = "R1"; e_lo = 1;
                e_rd = {8'h00, (lo_sel ? arr_word[15:8] : arr_word[7:0])};
            end
            checks++;
            if (host_rdata !== e_rd || lane_oe_lo !== e_lo || lane_oe_hi !== e_hi) begin
                fails++;
                $display("FAIL %s: rdata=%0h oe=%0b%0b expected rdata=%0h oe=%0b%0b",
                         rtag, host_rdata, lane_oe_hi, lane_oe_lo, e_rd, e_hi, e_lo);
            end
        end
    end

    task automatic wr(input bit bm, input logic [1:0] t, input logic [AW-1:0] a,
                      input bit sel, input logic [15:0] d);
        @(negedge clk);
        byte_mode = bm; wr_type = t; host_addr = a; lo_sel = sel; host_wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input bit bm, input bit c, input bit o, input bit st, input bit sel,
                      input logic [15:0] aw, input logic [7:0] sb);
        @(negedge clk);
        byte_mode = bm; ce_n = c; oe_n = o; rd_status = st; lo_sel = sel;
        arr_word = aw; stat_byte = sb;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wr(1, 2'b00, 17'h5, 1, 16'hA55A);     // R6: lo_sel ignored
        wr(0, 2'b00, 17'h6, 0, 16'hFF34);     // R5 low byte
        wr(0, 2'b00, 17'h7, 1, 16'h0012);     // R5 high byte
        wr(0, 2'b10, 17'h8, 0, 16'h1111);     // R10
        wr(1, 2'b11, 17'h8, 0, 16'h1111);     // R10
        wr(0, 2'b01, 17'h0, 0, 16'h0);        // R7 setup
        wr(0, 2'b00, 17'h9, 1, 16'h00AB);     // R7 first byte to high lane
        wr(0, 2'b00, 17'h3, 0, 16'h00CD);     // R7 -> ABCD at 9
        wr(0, 2'b01, 17'h0, 0, 16'h0);
        wr(0, 2'b00, 17'h1F, 0, 16'h0011);
        wr(0, 2'b00, 17'h2, 1, 16'h0022);     // R7 -> 2211 at 1F
        wr(1, 2'b01, 17'h0, 0, 16'h0);        // R8
        wr(1, 2'b00, 17'h4, 0, 16'h4444);     // still idle after R8
        wr(0, 2'b01, 17'h0, 0, 16'h0);
        wr(0, 2'b00, 17'hA, 0, 16'h0055);
        wr(0, 2'b10, 17'hA, 0, 16'h0);        // R9 broken after first byte
        wr(0, 2'b00, 17'hB, 1, 16'h0066);     // R9 then normal R5
        wr(0, 2'b01, 17'h0, 0, 16'h0);
        wr(0, 2'b01, 17'h0, 0, 16'h0);        // R9 second setup breaks
        wr(0, 2'b01, 17'h0, 0, 16'h0);
        wr(0, 2'b00, 17'hC, 0, 16'h0077);
        wr(1, 2'b00, 17'hC, 0, 16'h8888);     // R9 x16 data breaks
        rd(0, 0, 0, 0, 0, 16'hBEEF, 8'h80);   // R1
        rd(0, 0, 0, 0, 1, 16'hBEEF, 8'h80);   // R1
        rd(1, 0, 0, 0, 1, 16'hBEEF, 8'h80);   // R2
        rd(1, 0, 0, 1, 0, 16'hBEEF, 8'h80);   // R3
        rd(0, 0, 0, 1, 1, 16'hBEEF, 8'hC4);   // R3
        rd(1, 1, 0, 0, 0, 16'hBEEF, 8'h80);   // R4
        rd(1, 0, 1, 1, 0, 16'hBEEF, 8'h80);   // R4
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            byte_mode  = ($urandom_range(0, 3) != 0) ? 1'b0 : 1'b1;
            ce_n       = ($urandom_range(0, 4) == 0);
            oe_n       = ($urandom_range(0, 4) == 0);
            rd_status  = $urandom_range(0, 1) != 0;
            lo_sel     = $urandom_range(0, 1) != 0;
            arr_word   = 16'($urandom);
            stat_byte  = 8'($urandom);
            host_addr  = AW'($urandom);
            host_wdata = 16'($urandom);
            wr_type    = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
            wr_stb     = $urandom_range(0, 1) != 0;
        end
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule